// File: doc/BRIEF.md
# Synthesizer power-up register sequencer

This block is the host-side serial master for a mixer with an on-chip fractional-N synthesizer. A pulse on `start_full` makes it program the part after power-up. It writes register 5 with the PLL enable bit cleared, then holds off for a long settling wait. Next it writes register 5 again with the enable bit set, followed by registers 7, 6, 4, 3, 2 and 1. A second long wait gives band calibration time to finish. Register 0 is written last. A pulse on `start_retune` instead changes only the frequency, writing registers 0, 1 and 2 in that order with no long waits.

Each write is a 24-bit frame on a three-wire link: a serial clock, a data line and a latch strobe. The top 21 bits of every frame come from a parameter table indexed by register number. The bottom three bits carry the register number. The serial clock runs at the system clock divided by `2*SER_HALF`. The long wait is `WAIT_MS` milliseconds of a timebase that counts `CYC_PER_MS` system cycles per millisecond, so a bench can shorten it.

Top module: `synth_boot_seq`

## Requirements
- R1: While reset is held, and whenever the block is idle, `ser_clk`, `ser_le`, `ser_data` and `busy` are low. After reset, `done` is low.
- R2: Each frame carries exactly 24 bits, most significant bit first, one bit per rising edge of `ser_clk`. Frame bits 23..3 are the table entry `REG_TABLE[21*a +: 21]` of register a, and frame bits 2..0 are a. `ser_data` does not change while `ser_clk` is high.
- R3: `ser_clk` high and low phases each last at least `SER_HALF` system cycles. `ser_le` rises at least `SER_HALF` cycles after the last falling edge of `ser_clk`, stays high at least `SER_HALF` cycles, and is high only while `ser_clk` is low.
- R4: A full sequence writes registers in the order 5, 5, 7, 6, 4, 3, 2, 1, 0, which is nine frames.
- R5: In the first register-5 frame, frame bit 6 (the PLL enable) is 0. In the second it is 1. All its other bits come from the table.
- R6: From the latch of the first register-5 frame to the first serial clock edge of the next frame, at least `WAIT_MS*CYC_PER_MS` system cycles pass. The same wait separates the register-1 frame from the register-0 frame. All other gaps between frames are shorter than that wait.
- R7: A retune writes registers 0, 1, 2 in that order (three frames) with no long wait between them.
- R8: `busy` rises in the cycle after an accepted start. It stays high until the last frame's trailing gap ends, then falls.
- R9: A start pulse that arrives while `busy` is high is ignored. If both starts arrive in the same cycle, the full sequence is run.
- R10: `done` rises when `busy` falls at the end of a sequence. It holds until the next accepted start clears it, and it is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_full | input | 1 | Pulse to run the complete power-up sequence |
| start_retune | input | 1 | Pulse to rewrite registers 0, 1, 2 only |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence has completed |
| ser_clk | output | 1 | Serial clock to the device |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch strobe for the shifted word |

## Verification
The bench captures every frame at the pins and compares each one with a value it builds from the table. This exposes a swapped write order, a wrong address field, a lost or extra bit, or the enable bit left at its table value in the first register-5 write. It times the gaps between frames, so a sequencer that skips either long wait or inserts one in the wrong place is caught. It also measures serial phase widths and the latch placement, which exposes an off-by-one divider or a latch that overlaps the clock. Start pulses issued mid-sequence and simultaneous starts show whether a design restarts, or runs the retune, when it should not.

// File: rtl/synth_boot_seq_pkg.sv
package synth_boot_seq_pkg;

  localparam int FRAME_W  = 24;
  localparam int ADDR_W   = 3;
  localparam int PAY_W    = FRAME_W - ADDR_W;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int PLEN_BIT = 6;
  localparam int STEP_W   = 4;

  typedef enum logic {
    MODE_FULL   = 1'b0,
    MODE_RETUNE = 1'b1
  } seq_mode_t;

  typedef enum logic [1:0] {
    EN_KEEP = 2'd0,
    EN_CLR  = 2'd1,
    EN_SET  = 2'd2
  } en_force_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    en_force_t         en_force;
    logic              wait_after;
    logic              last;
  } seq_step_t;

  function automatic seq_step_t step_decode(seq_mode_t mode, logic [STEP_W-1:0] idx);
    seq_step_t s;
    s.addr       = '0;
    s.en_force   = EN_KEEP;
    s.wait_after = 1'b0;
    s.last       = 1'b0;
    if (mode == MODE_RETUNE) begin
      s.addr = idx[ADDR_W-1:0];
      s.last = (idx == STEP_W'(2));
    end else begin
      case (idx)
        4'd0: begin s.addr = 3'd5; s.en_force = EN_CLR; s.wait_after = 1'b1; end
        4'd1: begin s.addr = 3'd5; s.en_force = EN_SET; end
        4'd2: s.addr = 3'd7;
        4'd3: s.addr = 3'd6;
        4'd4: s.addr = 3'd4;
        4'd5: s.addr = 3'd3;
        4'd6: s.addr = 3'd2;
        4'd7: begin s.addr = 3'd1; s.wait_after = 1'b1; end
        default: begin s.addr = 3'd0; s.last = 1'b1; end
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/sbs_shifter.sv
module sbs_shifter
  import synth_boot_seq_pkg::*;
#(
  parameter int SER_HALF = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               ser_clk,
  output logic               ser_data,
  output logic               ser_le,
  output logic               done
);
  localparam int CW = (SER_HALF > 1) ? $clog2(SER_HALF) : 1;
  localparam int BW = $clog2(FRAME_W);

  typedef enum logic [2:0] {
    SH_IDLE, SH_LOW, SH_HIGH, SH_SETUP, SH_LATCH, SH_GAP
  } sh_state_t;

  sh_state_t          st_q;
  logic [CW-1:0]      div_q;
  logic [BW-1:0]      bit_q;
  logic [FRAME_W-1:0] sreg_q;
  logic               tick;

  assign tick = (div_q == CW'(SER_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SH_IDLE;
      div_q    <= '0;
      bit_q    <= '0;
      sreg_q   <= '0;
      ser_clk  <= 1'b0;
      ser_data <= 1'b0;
      ser_le   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st_q == SH_IDLE) begin
        div_q <= '0;
        if (load) begin
          sreg_q   <= frame;
          ser_data <= frame[FRAME_W-1];
          bit_q    <= '0;
          st_q     <= SH_LOW;
        end
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          case (st_q)
            SH_LOW: begin
              ser_clk <= 1'b1;
              st_q    <= SH_HIGH;
            end
            SH_HIGH: begin
              ser_clk <= 1'b0;
              if (bit_q == BW'(FRAME_W - 1)) begin
                st_q <= SH_SETUP;
              end else begin
                bit_q    <= bit_q + 1'b1;
                sreg_q   <= {sreg_q[FRAME_W-2:0], 1'b0};
                ser_data <= sreg_q[FRAME_W-2];
                st_q     <= SH_LOW;
              end
            end
            SH_SETUP: begin
              ser_le <= 1'b1;
              st_q   <= SH_LATCH;
            end
            SH_LATCH: begin
              ser_le <= 1'b0;
              st_q   <= SH_GAP;
            end
            default: begin
              ser_data <= 1'b0;
              done     <= 1'b1;
              st_q     <= SH_IDLE;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sbs_delay.sv
module sbs_delay #(
  parameter int CYC_PER_MS = 125000,
  parameter int WAIT_MS    = 101
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam int MW = (WAIT_MS > 1) ? $clog2(WAIT_MS) : 1;

  logic          run_q;
  logic [PW-1:0] pre_q;
  logic [MW-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      pre_q <= '0;
      ms_q  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run_q <= 1'b1;
        pre_q <= '0;
        ms_q  <= '0;
      end else if (run_q) begin
        if (pre_q == PW'(CYC_PER_MS - 1)) begin
          pre_q <= '0;
          if (ms_q == MW'(WAIT_MS - 1)) begin
            run_q <= 1'b0;
            done  <= 1'b1;
          end else begin
            ms_q <= ms_q + 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/synth_boot_seq.sv
module synth_boot_seq
  import synth_boot_seq_pkg::*;
#(
  parameter int                       SER_HALF   = 4,
  parameter int                       CYC_PER_MS = 125000,
  parameter int                       WAIT_MS    = 101,
  parameter logic [NUM_REGS*PAY_W-1:0] REG_TABLE = {
    21'h18421, 21'h0F1E2, 21'h15A5F, 21'h03C96,
    21'h1F00F, 21'h0ABCD, 21'h12345, 21'h05A3C}
) (
  input  logic clk,
  input  logic rst,
  input  logic start_full,
  input  logic start_retune,
  output logic busy,
  output logic done,
  output logic ser_clk,
  output logic ser_data,
  output logic ser_le
);
  typedef enum logic [1:0] {
    C_IDLE, C_LOAD, C_XFER, C_WAIT
  } ctl_state_t;

  ctl_state_t         st_q;
  seq_mode_t          mode_q;
  logic [STEP_W-1:0]  step_q;
  logic [FRAME_W-1:0] frame_q;
  logic               sh_load_q;
  logic               sh_done;
  logic               dly_start_q;
  logic               dly_done;
  seq_step_t          cur;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    cur     = step_decode(mode_q, step_q);
    frame_d = {REG_TABLE[int'(cur.addr)*PAY_W +: PAY_W], cur.addr};
    if (cur.en_force == EN_CLR) frame_d[PLEN_BIT] = 1'b0;
    if (cur.en_force == EN_SET) frame_d[PLEN_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= C_IDLE;
      mode_q      <= MODE_FULL;
      step_q      <= '0;
      frame_q     <= '0;
      sh_load_q   <= 1'b0;
      dly_start_q <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      sh_load_q   <= 1'b0;
      dly_start_q <= 1'b0;
      case (st_q)
        C_IDLE: begin
          if (start_full || start_retune) begin
            mode_q <= start_full ? MODE_FULL : MODE_RETUNE;
            step_q <= '0;
            busy   <= 1'b1;
            done   <= 1'b0;
            st_q   <= C_LOAD;
          end
        end
        C_LOAD: begin
          frame_q   <= frame_d;
          sh_load_q <= 1'b1;
          st_q      <= C_XFER;
        end
        C_XFER: begin
          if (sh_done) begin
            if (cur.last) begin
              busy <= 1'b0;
              done <= 1'b1;
              st_q <= C_IDLE;
            end else if (cur.wait_after) begin
              dly_start_q <= 1'b1;
              st_q        <= C_WAIT;
            end else begin
              step_q <= step_q + 1'b1;
              st_q   <= C_LOAD;
            end
          end
        end
        default: begin
          if (dly_done) begin
            step_q <= step_q + 1'b1;
            st_q   <= C_LOAD;
          end
        end
      endcase
    end
  end

  sbs_shifter #(.SER_HALF(SER_HALF)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (sh_load_q),
    .frame    (frame_q),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_le   (ser_le),
    .done     (sh_done)
  );

  sbs_delay #(.CYC_PER_MS(CYC_PER_MS), .WAIT_MS(WAIT_MS)) u_delay (
    .clk   (clk),
    .rst   (rst),
    .start (dly_start_q),
    .done  (dly_done)
  );
endmodule

// File: rtl/synth_boot_seq_chk.sv
module synth_boot_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_full,
  input logic start_retune,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_le
);
  assert_le_clk_low_R3: assert property (@(posedge clk) disable iff (rst)
    ser_le |-> !ser_clk);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && !ser_le && !ser_data));

  assert_data_stable_R2: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> $stable(ser_data));

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_full || start_retune));

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !start_full && !start_retune) |=> done);
endmodule

bind synth_boot_seq synth_boot_seq_chk u_chk (.*);

// File: tb/synth_boot_seq_tb.sv
module synth_boot_seq_tb;
  localparam int HALF = 4;
  localparam int CPM  = 20;
  localparam int WMS  = 3;
  localparam int WCYC = CPM * WMS;
  localparam logic [167:0] TBL = {
    21'h18421, 21'h0F1E2, 21'h15A5F, 21'h03C96,
    21'h1F00F, 21'h0ABCD, 21'h12345, 21'h05A3C};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_full = 1'b0;
  logic start_retune = 1'b0;
  logic busy, done, ser_clk, ser_data, ser_le;

  always #4 clk = ~clk;

  synth_boot_seq #(.SER_HALF(HALF), .CYC_PER_MS(CPM), .WAIT_MS(WMS), .REG_TABLE(TBL)) u_dut (
    .clk(clk), .rst(rst), .start_full(start_full), .start_retune(start_retune),
    .busy(busy), .done(done), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le));

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // pin monitor, sampled on the falling system clock edge
  int cyc = 0;
  logic p_sclk = 1'b0, p_le = 1'b0;
  int t_rise = 0, t_fall = -1, t_lerise = 0, t_lefall = -1;
  logic [23:0] sh = '0;
  int nb = 0, cur_gap = -1, nlog = 0;
  logic [23:0] log_f [16];
  int log_nb [16];
  int log_gap [16];
  int min_high = 1000, min_low = 1000, min_setup = 1000, min_le = 1000;
  int le_on_clk = 0;

  always @(negedge clk) begin
    cyc++;
    if (ser_clk && !p_sclk) begin
      if (nb == 0) cur_gap = (t_lefall >= 0) ? cyc - t_lefall : -1;
      else if (cyc - t_fall < min_low) min_low = cyc - t_fall;
      sh = {sh[22:0], ser_data};
      nb++;
      t_rise = cyc;
    end
    if (!ser_clk && p_sclk) begin
      if (cyc - t_rise < min_high) min_high = cyc - t_rise;
      t_fall = cyc;
    end
    if (ser_le && ser_clk) le_on_clk++;
    if (ser_le && !p_le) begin
      if (cyc - t_fall < min_setup) min_setup = cyc - t_fall;
      if (nlog < 16) begin
        log_f[nlog] = sh;
        log_nb[nlog] = nb;
        log_gap[nlog] = cur_gap;
      end
      nlog++;
      nb = 0;
      t_lerise = cyc;
    end
    if (!ser_le && p_le) begin
      if (cyc - t_lerise < min_le) min_le = cyc - t_lerise;
      t_lefall = cyc;
    end
    p_sclk = ser_clk;
    p_le = ser_le;
  end

  function automatic logic [23:0] exp_frame(input int a, input int en);
    logic [23:0] f;
    f = {TBL[a*21 +: 21], 3'(a)};
    if (en == 0) f[6] = 1'b0;
    if (en == 1) f[6] = 1'b1;
    return f;
  endfunction

  task automatic clear_log();
    nlog = 0;
    t_lefall = -1;
    nb = 0;
  endtask

  task automatic pulse(input logic f, input logic r);
    @(negedge clk);
    start_full = f;
    start_retune = r;
    @(negedge clk);
    start_full = 1'b0;
    start_retune = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic check_full(input string tag);
    int ord [9] = '{5, 5, 7, 6, 4, 3, 2, 1, 0};
    chk(nlog == 9, "R4", {tag, " frame count"}, nlog, 9);
    for (int i = 0; i < 9 && i < nlog; i++) begin
      int en = (i == 0) ? 0 : ((i == 1) ? 1 : 2);
      chk(log_f[i] == exp_frame(ord[i], en), (i < 2) ? "R5" : "R4",
          $sformatf("%s frame %0d", tag, i), log_f[i], exp_frame(ord[i], en));
      chk(log_nb[i] == 24, "R2", $sformatf("%s bits in frame %0d", tag, i), log_nb[i], 24);
      if (i == 1 || i == 8)
        chk(log_gap[i] >= WCYC, "R6", $sformatf("%s long gap %0d", tag, i), log_gap[i], WCYC);
      else if (i > 1)
        chk(log_gap[i] < WCYC, "R6", $sformatf("%s short gap %0d", tag, i), log_gap[i], WCYC);
    end
    chk(done && !busy, "R10", {tag, " done after full"}, {done, busy}, 2'b10);
  endtask

  initial begin
    #(200000 * 8);
    chk(0, "WATCHDOG", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({busy, done, ser_clk, ser_le, ser_data} == 5'b0, "R1", "outputs in reset",
        {busy, done, ser_clk, ser_le, ser_data}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, ser_clk, ser_le, ser_data} == 5'b0, "R1", "outputs after reset",
        {busy, done, ser_clk, ser_le, ser_data}, 0);

    // full sequence, with starts injected while busy (R9)
    clear_log();
    @(negedge clk);
    start_full = 1'b1;
    @(negedge clk);
    start_full = 1'b0;
    chk(busy == 1'b1, "R8", "busy one cycle after start", busy, 1);
    chk(done == 1'b0, "R10", "done low while busy", done, 0);
    repeat (300) @(negedge clk);
    pulse(1'b0, 1'b1);
    repeat (200) @(negedge clk);
    pulse(1'b1, 1'b0);
    wait_done();
    check_full("R9 busy starts ignored");
    repeat (20) @(negedge clk);
    chk(nlog == 9, "R9", "no frames after completion", nlog, 9);
    chk(done == 1'b1, "R10", "done held while idle", done, 1);

    // retune
    clear_log();
    pulse(1'b0, 1'b1);
    chk(busy && !done, "R10", "retune clears done", {busy, done}, 2'b10);
    wait_done();
    chk(nlog == 3, "R7", "retune frame count", nlog, 3);
    for (int i = 0; i < 3 && i < nlog; i++) begin
      chk(log_f[i] == exp_frame(i, 2), "R7", $sformatf("retune frame %0d", i),
          log_f[i], exp_frame(i, 2));
      if (i > 0)
        chk(log_gap[i] < WCYC, "R7", $sformatf("retune gap %0d", i), log_gap[i], WCYC);
    end

    // both starts together: full wins
    clear_log();
    pulse(1'b1, 1'b1);
    wait_done();
    check_full("R9 simultaneous starts");

    // second retune straight after a full run
    clear_log();
    pulse(1'b0, 1'b1);
    wait_done();
    chk(nlog == 3 && log_f[0] == exp_frame(0, 2), "R7", "second retune first frame",
        log_f[0], exp_frame(0, 2));

    // R3: serial timing over every frame sent
    chk(min_high >= HALF, "R3", "min clock high", min_high, HALF);
    chk(min_low >= HALF, "R3", "min clock low", min_low, HALF);
    chk(min_setup >= HALF, "R3", "clock to latch setup", min_setup, HALF);
    chk(min_le >= HALF, "R3", "latch pulse width", min_le, HALF);
    chk(le_on_clk == 0, "R3", "latch while clock high", le_on_clk, 0);
    repeat (5) @(negedge clk);
    chk({busy, ser_clk, ser_le, ser_data} == 4'b0, "R1", "idle lines",
        {busy, ser_clk, ser_le, ser_data}, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule